// File: doc/BRIEF.md
# Key-Locked GPIO Bank

A bank of up to 32 general-purpose pins behind a 32-bit register bus with a combinational read path. Every pin carries an output data bit and a two-bit drive mode. The mode selects one of four pad behaviours: input only, push-pull, pull-low only (open-drain style) or pull-high only (open-source style). The block drives an output-enable and an output-value line to each pad and samples each pad's input through a two-flop synchronizer.

Output data is changed only through write-one set and clear registers. The two mode registers can be written directly, read back for save and restore, and modified through write-one set or clear aliases. A mode write takes effect only while a separate key register is active. That key register has its own select input. Writing the right 16-bit key to it activates it, and writing any other value releases it. This protects pin direction from stray software writes, while data writes are never blocked. The pin count is a parameter, so a short bank can be built from the same code.

Top module: `gpio_lock_bank`

## Requirements
- R1: After a synchronous reset both mode registers and the output data are zero, the key register is inactive, and pad_oe and pad_out are all zero.
- R2: A write with key_sel high loads the key state from wdata[15:0] only: 0xD42F activates it and any other value releases it. A read with key_sel high returns bit 31 set while the key is active and all other bits zero.
- R3: Writes to mode1 (0x08), mode0 (0x0C), mode1-clear (0x50), mode0-set (0x54) and mode0-clear (0x58) change nothing while the key register is inactive.
- R4: A write to data-set (0x14) sets, and a write to data-clear (0x18), clears each output data bit whose wdata bit is 1. It leaves the other bits unchanged. These writes work whether or not the key is active.
- R5: While the key is active, 0x08 and 0x0C load mode1 and mode0 directly, 0x54 sets the mode0 bits written as 1, and 0x50 and 0x58 clear the mode1 and mode0 bits written as 1. Both mode registers read back at their direct offsets.
- R6: With {mode1,mode0} per pin, pad_oe is 0 for 00, 1 for 01, the inverse of the data bit for 10, and the data bit for 11.
- R7: pad_out of each pin equals its output data bit.
- R8: A value on pad_in present at a clock edge reads back at offset 0x04 after the following edge, and not before.
- R9: Register bits at and above the pin count read as zero, and writes to them have no effect.
- R10: Reads of any offset other than 0x04, 0x08 and 0x0C with key_sel low return zero, including the write-only set and clear offsets.
- R11: While key_sel is high, a write goes only to the key register, whatever the value of bus_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_sel | input | 1 | Selects the key register instead of the bank registers |
| bus_addr | input | ADDR_W | Byte offset of the bank register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| pad_in | input | PINS | Asynchronous pad input levels |
| pad_oe | output | PINS | Per-pin output enable |
| pad_out | output | PINS | Per-pin output value |

## Verification
Two functions can land in the same cycle. The first is a key-register access and a bank-register decode: the bench holds key_sel high with bus_addr pointing at a mode register and writes the key value. It then judges that the key state changed and that the mode register did not. The second is a key change directly before a mode write. A release written in the cycle just before a mode write must drop that write, and an acquire in the cycle just before must let it through. A behavioural model updated at each edge predicts bus_rdata, pad_oe and pad_out, and these are compared every cycle.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the key-locked GPIO bank.
// Assumes byte offsets fit in 8 bits; the top widens them to its address width.
package gpio_bank_pkg;
    localparam logic [7:0] OFS_DIN    = 8'h04;
    localparam logic [7:0] OFS_MODE1  = 8'h08;
    localparam logic [7:0] OFS_MODE0  = 8'h0C;
    localparam logic [7:0] OFS_DSET   = 8'h14;
    localparam logic [7:0] OFS_DCLR   = 8'h18;
    localparam logic [7:0] OFS_M1CLR  = 8'h50;
    localparam logic [7:0] OFS_M0SET  = 8'h54;
    localparam logic [7:0] OFS_M0CLR  = 8'h58;
    localparam logic [15:0] UNLOCK_KEY = 16'hD42F;

    typedef enum logic [1:0] {
        PM_INPUT    = 2'b00,
        PM_PUSHPULL = 2'b01,
        PM_SINK     = 2'b10,
        PM_SOURCE   = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/gpio_key_lock.sv
`timescale 1ns/1ps
// Key register that gates mode writes.
// Holds one state bit: set when the exact key is written, cleared by any
// other written value. Assumes wr_en is a single-cycle strobe.
module gpio_key_lock
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] key,
    output logic        active
);

    // Key state: loaded on every write, inactive after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (wr_en)
            active <= (key == UNLOCK_KEY);
    end

    // R2: without a write the key state holds
    p_key_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(active));

    // R2: after a write the state reflects only whether the key matched
    p_key_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (active == ($past(key) == 16'hD42F)));

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for the pad inputs, one chain per pin.
// Assumes each pad input is a level signal; no glitch filtering.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    for (genvar g = 0; g < W; g++) begin : g_chain
        logic stage1;
        logic stage2;
        // Two-stage capture of one pad level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= async_in[g];
                stage2 <= stage1;
            end
        end
        assign sync_out[g] = stage2;
    end

    // R8: output equals the input sampled two edges earlier
    p_sync_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/gpio_pad_drive.sv
`timescale 1ns/1ps
// Per-pin pad driver: maps two mode bits and the data bit to an enable.
// Assumes the pad drives pad_out when pad_oe is high and floats otherwise.
module gpio_pad_drive
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mode1,
    input  logic [W-1:0] mode0,
    input  logic [W-1:0] dout,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out
);

    for (genvar g = 0; g < W; g++) begin : g_pin
        pin_mode_e mode;
        assign mode = pin_mode_e'({mode1[g], mode0[g]});
        // Enable decode for one pin.
        always_comb begin
            unique case (mode)
                PM_INPUT:    pad_oe[g] = 1'b0;
                PM_PUSHPULL: pad_oe[g] = 1'b1;
                PM_SINK:     pad_oe[g] = ~dout[g];
                PM_SOURCE:   pad_oe[g] = dout[g];
                default:     pad_oe[g] = 1'b0;
            endcase
        end
        assign pad_out[g] = dout[g];
    end

    // R6: an input pin never drives
    p_input_floats_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mode1 & ~mode0 & pad_oe) == '0));

    // R6: a driven pin in a one-sided mode drives only its own level
    p_one_sided_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode1 & pad_oe & (mode0 ^ pad_out)) == '0));

endmodule

// File: rtl/gpio_lock_bank.sv
`timescale 1ns/1ps
// GPIO bank with key-gated drive modes.
// Holds the mode and data registers, decodes the register bus and reads
// back combinationally. Assumes 1 <= PINS <= 32 and single-cycle writes.
module gpio_lock_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out
);

    localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFS_DIN);
    localparam logic [ADDR_W-1:0] A_MODE1 = ADDR_W'(OFS_MODE1);
    localparam logic [ADDR_W-1:0] A_MODE0 = ADDR_W'(OFS_MODE0);
    localparam logic [ADDR_W-1:0] A_DSET  = ADDR_W'(OFS_DSET);
    localparam logic [ADDR_W-1:0] A_DCLR  = ADDR_W'(OFS_DCLR);
    localparam logic [ADDR_W-1:0] A_M1CLR = ADDR_W'(OFS_M1CLR);
    localparam logic [ADDR_W-1:0] A_M0SET = ADDR_W'(OFS_M0SET);
    localparam logic [ADDR_W-1:0] A_M0CLR = ADDR_W'(OFS_M0CLR);

    logic [PINS-1:0] mode0_q;
    logic [PINS-1:0] mode1_q;
    logic [PINS-1:0] dout_q;
    logic [PINS-1:0] din_sync;
    logic [PINS-1:0] wbits;
    logic            key_active;
    logic            bank_wr;
    logic            mode_wr;

    assign wbits   = bus_wdata[PINS-1:0];
    assign bank_wr = bus_wr && !key_sel;
    assign mode_wr = bank_wr && key_active;

    gpio_key_lock i_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr && key_sel),
        .key    (bus_wdata[15:0]),
        .active (key_active)
    );

    gpio_in_sync #(.W(PINS)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (din_sync)
    );

    gpio_pad_drive #(.W(PINS)) i_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode1   (mode1_q),
        .mode0   (mode0_q),
        .dout    (dout_q),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    // Output data: write-one set and clear, never key-gated.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= '0;
        else if (bank_wr) begin
            if (bus_addr == A_DSET)
                dout_q <= dout_q | wbits;
            else if (bus_addr == A_DCLR)
                dout_q <= dout_q & ~wbits;
        end
    end

    // Mode0: direct load, set and clear while the key is active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode0_q <= '0;
        else if (mode_wr) begin
            if (bus_addr == A_MODE0)
                mode0_q <= wbits;
            else if (bus_addr == A_M0SET)
                mode0_q <= mode0_q | wbits;
            else if (bus_addr == A_M0CLR)
                mode0_q <= mode0_q & ~wbits;
        end
    end

    // Mode1: direct load and clear while the key is active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode1_q <= '0;
        else if (mode_wr) begin
            if (bus_addr == A_MODE1)
                mode1_q <= wbits;
            else if (bus_addr == A_M1CLR)
                mode1_q <= mode1_q & ~wbits;
        end
    end

    // Read mux: key status, readable bank registers, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (key_sel)
            bus_rdata[31] = key_active;
        else if (bus_addr == A_DIN)
            bus_rdata = 32'(din_sync);
        else if (bus_addr == A_MODE1)
            bus_rdata = 32'(mode1_q);
        else if (bus_addr == A_MODE0)
            bus_rdata = 32'(mode0_q);
    end

    // R3: modes hold while the key is inactive
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !key_active |=> ($stable(mode0_q) && $stable(mode1_q)));

    // R11: a key access leaves the bank registers alone
    p_key_access_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        key_sel |=> ($stable(mode0_q) && $stable(mode1_q) && $stable(dout_q)));

    // R4: every bit written to data-set is high afterwards
    p_data_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !key_sel && bus_addr == A_DSET)
        |=> ((pad_out & $past(wbits)) == $past(wbits)));

    // R2: key read shows only the status bit
    p_key_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_sel |-> (bus_rdata[30:0] == 31'd0));

endmodule

// File: tb/test_gpio_lock_bank.sv
`timescale 1ns/1ps
module test_gpio_lock_bank;
    localparam int P = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_sel = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [P-1:0]  pad_in = '0;
    logic [P-1:0]  pad_oe;
    logic [P-1:0]  pad_out;

    int checks = 0;
    int fails  = 0;
    bit model_live = 0;

    always #2 clk = ~clk;

    gpio_lock_bank #(.PINS(P), .ADDR_W(8)) i_gpio_lock_bank (
        .clk(clk), .rst_n(rst_n), .key_sel(key_sel), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out));

    // Behavioural reference model
    int m_mode0, m_mode1, m_data, m_key;
    int in_hist[$];
    int mask = (1 << P) - 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode0 = 0; m_mode1 = 0; m_data = 0; m_key = 0;
            in_hist.delete();
            model_live = 1;
        end else begin
            int w;
            w = int'(bus_wdata) & mask;
            if (bus_wr && key_sel)
                m_key = (bus_wdata[15:0] == 16'hD42F) ? 1 : 0;
            else if (bus_wr) begin
                case (bus_addr)
                    8'h14: m_data = m_data | w;
                    8'h18: m_data = m_data & ~w;
                    default: ;
                endcase
                if (m_key == 1) begin
                    case (bus_addr)
                        8'h08: m_mode1 = w;
                        8'h0C: m_mode0 = w;
                        8'h50: m_mode1 = m_mode1 & ~w;
                        8'h54: m_mode0 = m_mode0 | w;
                        8'h58: m_mode0 = m_mode0 & ~w;
                        default: ;
                    endcase
                end
            end
            in_hist.push_back(int'(pad_in));
            if (in_hist.size() > 2) void'(in_hist.pop_front());
        end
    end

    function automatic int exp_oe();
        int r = 0;
        for (int i = 0; i < P; i++) begin
            int md = ((m_mode1 >> i) & 1) * 2 + ((m_mode0 >> i) & 1);
            int d = (m_data >> i) & 1;
            int e = (md == 1) ? 1 : (md == 2) ? 1 - d : (md == 3) ? d : 0;
            r = r | (e << i);
        end
        return r;
    endfunction

    function automatic int exp_read();
        if (key_sel) return (m_key == 1) ? 32'h8000_0000 : 0;
        case (bus_addr)
            8'h04: return (in_hist.size() == 2) ? in_hist[0] : 0;
            8'h08: return m_mode1;
            8'h0C: return m_mode0;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
        end
    endtask

    // Per-cycle comparison against the model, away from the edge
    always @(posedge clk) begin
        #1;
        if (model_live) begin
            chk("R6 model pad_oe", int'(pad_oe), exp_oe());
            chk("R7 model pad_out", int'(pad_out), m_data);
            chk("R10 model read", int'(bus_rdata), exp_read());
        end
    end

    task automatic wr(input logic sel, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        key_sel = sel; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; key_sel = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] a, output int v);
        @(negedge clk);
        key_sel = sel; bus_addr = a; bus_wr = 1'b0;
        @(posedge clk);
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, 8'h0C, v); chk("R1 mode0", v, 0);
        rd(0, 8'h08, v); chk("R1 mode1", v, 0);
        rd(1, 8'h00, v); chk("R1 key", v, 0);
        chk("R1 pad_oe", int'(pad_oe), 0);
        chk("R1 pad_out", int'(pad_out), 0);
        // R3 writes dropped while unlocked
        wr(0, 8'h0C, 32'h3F);
        wr(0, 8'h54, 32'h01);
        rd(0, 8'h0C, v); chk("R3 mode0 locked", v, 0);
        // R2 activate, upper bits ignored
        wr(1, 8'h00, 32'h1234_D42F);
        rd(1, 8'h00, v); chk("R2 key active", v, 32'h8000_0000);
        // R11 key access with mode address present
        wr(1, 8'h0C, 32'h0000_D42F);
        rd(0, 8'h0C, v); chk("R11 mode0 untouched", v, 0);
        rd(1, 8'h0C, v); chk("R11 key still active", v, 32'h8000_0000);
        // R5 and R9 mode writes while active
        wr(0, 8'h0C, 32'hFFFF_FFFF);
        rd(0, 8'h0C, v); chk("R9 mode0 width", v, 32'h3F);
        wr(0, 8'h58, 32'h05);
        rd(0, 8'h0C, v); chk("R5 mode0 clear", v, 32'h3A);
        wr(0, 8'h08, 32'h0C);
        wr(0, 8'h50, 32'h04);
        rd(0, 8'h08, v); chk("R5 mode1 load clear", v, 32'h08);
        wr(0, 8'h54, 32'h01);
        rd(0, 8'h0C, v); chk("R5 mode0 set", v, 32'h3B);
        // R4 data set and clear
        wr(0, 8'h14, 32'hFFFF_FFFF);
        chk("R9 pad_out width", int'(pad_out), 32'h3F);
        wr(0, 8'h18, 32'h0A);
        chk("R7 pad_out", int'(pad_out), 32'h35);
        chk("R6 mixed modes", int'(pad_oe), 32'h33);
        // R6 sink and source
        wr(0, 8'h08, 32'h3F);
        wr(0, 8'h0C, 32'h00);
        chk("R6 sink", int'(pad_oe), 32'h0A);
        wr(0, 8'h0C, 32'h3F);
        chk("R6 source", int'(pad_oe), 32'h35);
        // R2 release, then R3 drop right after
        wr(1, 8'h00, 32'h0);
        wr(0, 8'h0C, 32'h0);
        wr(0, 8'h50, 32'h3F);
        rd(0, 8'h0C, v); chk("R3 mode0 after release", v, 32'h3F);
        rd(0, 8'h08, v); chk("R3 mode1 after release", v, 32'h3F);
        rd(1, 8'h00, v); chk("R2 released", v, 0);
        // R4 data writes not gated
        wr(0, 8'h14, 32'h0A);
        chk("R4 set unlocked", int'(pad_out), 32'h3F);
        // R2 wrong key releases
        wr(1, 8'h00, 32'hD42F);
        wr(1, 8'h00, 32'hD42E);
        rd(1, 8'h00, v); chk("R2 wrong key", v, 0);
        // R8 synchronizer latency
        @(negedge clk);
        pad_in = 6'h2A; bus_addr = 8'h04; key_sel = 1'b0;
        @(posedge clk); #1;
        chk("R8 not yet", int'(bus_rdata), 0);
        @(posedge clk); #1;
        chk("R8 visible", int'(bus_rdata), 32'h2A);
        // R10 unmapped and write-only offsets
        rd(0, 8'h14, v); chk("R10 dset reads zero", v, 0);
        rd(0, 8'h50, v); chk("R10 m1clr reads zero", v, 0);
        rd(0, 8'h20, v); chk("R10 unmapped", v, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule